// File: doc/BRIEF.md
# Segment Attribute Table

This block holds one small attribute record for every equal-sized segment of a 32-bit address space. With the default parameters the space is cut into 256 segments of 16 MB, and the top eight bits of an address name the segment. Each record carries two flags. One says whether accesses to the segment may be cached. The other says whether the segment may be prefetched.

A memory controller places the table beside its request path. It presents the access address on the lookup port and gets the two flags back in the same cycle. Configuration goes through a plain register port that holds a write strobe, a word index and a 32-bit data word. Reads on that port are combinational. The lowest sixteen segments describe on-chip memory, and their records are fixed at zero.

Top module: `segattr_table`

## Requirements
- R1: While reset is asserted and after it is released, every record reads as 0x00000000 and both lookup flags are 0 for every address.
- R2: The lookup selects the record whose index equals address bits [31:24]. `lk_cacheable` is bit 0 of that record and `lk_prefetch` is bit 3.
- R3: A write to an index from 16 to 255 stores data bits 0 and 3. A later read of that index returns them in the same bit positions.
- R4: Every bit other than 0 and 3 reads as zero, whatever value was written. For example, writing 0xFFFFFFFF reads back as 0x00000009.
- R5: A write to an index from 0 to 15 has no effect. Those records read as zero, and lookups into those segments return both flags as 0.
- R6: A write becomes visible to lookups in the cycle after the clock edge that accepts it. A lookup into the same segment in the write cycle returns the old value.
- R7: Address bits [23:0] have no effect on the lookup flags.
- R8: A write changes only the record it names. All other records keep their values.
- R9: `cfg_rdata` follows `cfg_idx` combinationally, with no clock edge needed between a change of index and valid read data.

Records are numbered by word index 0 to 255, and a record's index equals the segment it controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 8 | Record index for both read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of record `cfg_idx` |
| lk_addr | input | 32 | Access address to classify |
| lk_cacheable | output | 1 | Segment may be cached |
| lk_prefetch | output | 1 | Segment may be prefetched |

## Verification
A configuration write and a lookup into the same segment can occur in the same cycle. The bench provokes this by holding the write strobe, the index and the lookup address together for one clock period. It samples the flags before the edge, where it expects the old value, and again after the edge, where it expects the new value. The same collision is also driven against a locked segment, where both samples must stay at zero.

// File: rtl/segattr_pkg.sv
package segattr_pkg;
   // Stored attribute pair for one segment
   typedef struct packed {
      logic pref;
      logic cache;
   } seg_attr_t;

   localparam seg_attr_t SEG_ATTR_CLEAR = '{pref: 1'b0, cache: 1'b0};
endpackage

// File: rtl/segattr_store.sv
module segattr_store
   import segattr_pkg::*;
#(
   parameter int SEG_BITS = 8,
   parameter int LOCKED   = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEG_BITS-1:0]            wr_idx,
   input  seg_attr_t                      wr_attr,
   output seg_attr_t [(1<<SEG_BITS)-1:0]  attr_q
);
   localparam int NSEG = 1 << SEG_BITS;
   localparam logic [SEG_BITS-1:0] LOCK_IDX = SEG_BITS'(LOCKED);

   generate
      if (LOCKED > NSEG) begin : g_bad_lock
         $error("segattr_store: LOCKED exceeds segment count");
      end
      for (genvar g = 0; g < NSEG; g++) begin : g_ent
         if (g < LOCKED) begin : g_fixed
            assign attr_q[g] = SEG_ATTR_CLEAR;
         end else begin : g_reg
            seg_attr_t ent_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  ent_q <= SEG_ATTR_CLEAR;
               else if (wr_en && wr_idx == SEG_BITS'(g))
                  ent_q <= wr_attr;
            end
            assign attr_q[g] = ent_q;
         end
      end
   endgenerate

   // R5
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (LOCKED > 0) && wr_idx < LOCK_IDX) |=> $stable(attr_q));

   // R3
   open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= LOCK_IDX) |=> attr_q[$past(wr_idx)] == $past(wr_attr));
endmodule

// File: rtl/segattr_rdmux.sv
module segattr_rdmux
   import segattr_pkg::*;
#(
   parameter int SEG_BITS  = 8,
   parameter int DATA_W    = 32,
   parameter int CACHE_BIT = 0,
   parameter int PREF_BIT  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  seg_attr_t [(1<<SEG_BITS)-1:0]  attr_q,
   input  logic [SEG_BITS-1:0]            rd_idx,
   output logic [DATA_W-1:0]              rd_data
);
   localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'(1) << CACHE_BIT) | (DATA_W'(1) << PREF_BIT);

   generate
      if (CACHE_BIT == PREF_BIT || CACHE_BIT >= DATA_W || PREF_BIT >= DATA_W) begin : g_bad_bits
         $error("segattr_rdmux: attribute bit positions invalid");
      end
   endgenerate

   seg_attr_t sel;
   always_comb begin
      sel = attr_q[rd_idx];
      rd_data = '0;
      rd_data[CACHE_BIT] = sel.cache;
      rd_data[PREF_BIT]  = sel.pref;
   end

   // R4
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE_MASK) == '0);
endmodule

// File: rtl/segattr_lookup.sv
module segattr_lookup
   import segattr_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SEG_BITS = 8
) (
   input  seg_attr_t [(1<<SEG_BITS)-1:0]  attr_q,
   input  logic [ADDR_W-1:0]              addr,
   output logic                           cacheable,
   output logic                           prefetch
);
   generate
      if (SEG_BITS > ADDR_W || SEG_BITS < 1) begin : g_bad_seg
         $error("segattr_lookup: SEG_BITS out of range");
      end
   endgenerate

   logic [SEG_BITS-1:0] seg;
   assign seg       = addr[ADDR_W-1 -: SEG_BITS];
   assign cacheable = attr_q[seg].cache;
   assign prefetch  = attr_q[seg].pref;
endmodule

// File: rtl/segattr_table.sv
module segattr_table
   import segattr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_BITS  = 8,
   parameter int DATA_W    = 32,
   parameter int LOCKED    = 16,
   parameter int CACHE_BIT = 0,
   parameter int PREF_BIT  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [SEG_BITS-1:0] cfg_idx,
   input  logic [DATA_W-1:0]   cfg_wdata,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic [ADDR_W-1:0]   lk_addr,
   output logic                lk_cacheable,
   output logic                lk_prefetch
);
   localparam int NSEG = 1 << SEG_BITS;
   localparam logic [SEG_BITS-1:0] LOCK_IDX = SEG_BITS'(LOCKED);

   seg_attr_t [NSEG-1:0] attr_q;
   seg_attr_t            wr_attr;
   logic                 unused_bits;

   assign wr_attr.cache = cfg_wdata[CACHE_BIT];
   assign wr_attr.pref  = cfg_wdata[PREF_BIT];
   assign unused_bits   = ^{cfg_wdata, lk_addr};

   segattr_store #(.SEG_BITS(SEG_BITS), .LOCKED(LOCKED)) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_idx(cfg_idx),
      .wr_attr(wr_attr), .attr_q(attr_q));

   segattr_rdmux #(.SEG_BITS(SEG_BITS), .DATA_W(DATA_W),
                   .CACHE_BIT(CACHE_BIT), .PREF_BIT(PREF_BIT)) i_rdmux (
      .clk(clk), .rst_n(rst_n), .attr_q(attr_q), .rd_idx(cfg_idx),
      .rd_data(cfg_rdata));

   segattr_lookup #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) i_lookup (
      .attr_q(attr_q), .addr(lk_addr),
      .cacheable(lk_cacheable), .prefetch(lk_prefetch));

   // R2
   lookup_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx == lk_addr[ADDR_W-1 -: SEG_BITS]) |->
         (lk_cacheable == cfg_rdata[CACHE_BIT] && lk_prefetch == cfg_rdata[PREF_BIT]));

   // R5
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((LOCKED > 0) && cfg_idx < LOCK_IDX) |-> cfg_rdata == '0);

   // R6
   write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_idx >= LOCK_IDX && $stable(lk_addr) &&
       lk_addr[ADDR_W-1 -: SEG_BITS] == cfg_idx) |=>
         (lk_cacheable == $past(cfg_wdata[CACHE_BIT])));
endmodule

// File: tb/test_segattr_table.sv
module test_segattr_table;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] lk_addr = '0;
   logic        lk_cacheable, lk_prefetch;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   segattr_table i_segattr_table (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
      .lk_cacheable(lk_cacheable), .lk_prefetch(lk_prefetch));

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] idx, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [7:0] idx, logic [31:0] exp);
      cfg_idx = idx; #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic lk_chk(string req, logic [31:0] a, logic c, logic p);
      lk_addr = a; #1;
      chk(req, {30'd0, lk_prefetch, lk_cacheable}, {30'd0, p, c});
   endtask

   task automatic t_reset;
      rd_chk("R1", 8'd0, 32'h0);
      rd_chk("R1", 8'd16, 32'h0);
      rd_chk("R1", 8'd255, 32'h0);
      lk_chk("R1", 32'h8000_0000, 1'b0, 1'b0);
      lk_chk("R1", 32'hFF12_3456, 1'b0, 1'b0);
   endtask

   task automatic t_basic;
      wr(8'h40, 32'h1);
      rd_chk("R3", 8'h40, 32'h1);
      lk_chk("R2", 32'h4000_0000, 1'b1, 1'b0);
      wr(8'h80, 32'h8);
      rd_chk("R3", 8'h80, 32'h8);
      lk_chk("R2", 32'h8000_0010, 1'b0, 1'b1);
      wr(8'd16, 32'h9);
      rd_chk("R3", 8'd16, 32'h9);
      lk_chk("R2", 32'h1000_0000, 1'b1, 1'b1);
      wr(8'd255, 32'h9);
      lk_chk("R2", 32'hFFFF_FFFF, 1'b1, 1'b1);
   endtask

   task automatic t_reserved;
      wr(8'hA0, 32'hFFFF_FFFF);
      rd_chk("R4", 8'hA0, 32'h9);
      wr(8'hA1, 32'hFFFF_FFF6);
      rd_chk("R4", 8'hA1, 32'h0);
      lk_chk("R4", 32'hA100_0000, 1'b0, 1'b0);
   endtask

   task automatic t_locked;
      wr(8'd5, 32'hFFFF_FFFF);
      rd_chk("R5", 8'd5, 32'h0);
      lk_chk("R5", 32'h0500_0000, 1'b0, 1'b0);
      wr(8'd15, 32'h9);
      rd_chk("R5", 8'd15, 32'h0);
      lk_chk("R5", 32'h0FFF_FFFF, 1'b0, 1'b0);
      wr(8'd0, 32'h9);
      lk_chk("R5", 32'h0000_0000, 1'b0, 1'b0);
   endtask

   task automatic t_collide;
      @(negedge clk);
      lk_addr = 32'h3012_3456;
      cfg_wr = 1'b1; cfg_idx = 8'h30; cfg_wdata = 32'h1;
      #1;
      chk("R6 old", {31'd0, lk_cacheable}, 32'h0);
      @(negedge clk);
      cfg_wr = 1'b0; #1;
      chk("R6 new", {31'd0, lk_cacheable}, 32'h1);
      // collision on a locked segment
      @(negedge clk);
      lk_addr = 32'h0300_0000;
      cfg_wr = 1'b1; cfg_idx = 8'h03; cfg_wdata = 32'h9;
      #1;
      chk("R6 lock old", {30'd0, lk_prefetch, lk_cacheable}, 32'h0);
      @(negedge clk);
      cfg_wr = 1'b0; #1;
      chk("R6 lock new", {30'd0, lk_prefetch, lk_cacheable}, 32'h0);
   endtask

   task automatic t_lowbits;
      lk_chk("R7", 32'h4000_0000, 1'b1, 1'b0);
      lk_chk("R7", 32'h40FF_FFFF, 1'b1, 1'b0);
      lk_chk("R7", 32'h40A5_5A5A, 1'b1, 1'b0);
      lk_chk("R7", 32'h3FFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_isolate;
      rd_chk("R8", 8'h3F, 32'h0);
      rd_chk("R8", 8'h41, 32'h0);
      rd_chk("R8", 8'h40, 32'h1);
      rd_chk("R8", 8'h80, 32'h8);
      wr(8'h40, 32'h0);
      lk_chk("R8", 32'h4000_0000, 1'b0, 1'b0);
      rd_chk("R8", 8'h80, 32'h8);
   endtask

   task automatic t_comb_read;
      @(negedge clk);
      cfg_idx = 8'hA0; #1;
      chk("R9", cfg_rdata, 32'h9);
      cfg_idx = 8'h80; #1;
      chk("R9", cfg_rdata, 32'h8);
      cfg_idx = 8'hA1; #1;
      chk("R9", cfg_rdata, 32'h0);
   endtask

   task automatic t_rereset;
      @(negedge clk);
      rst_n = 1'b0; #1;
      rd_chk("R1", 8'hA0, 32'h0);
      lk_chk("R1", 32'hFF00_0000, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1", 8'h80, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_reserved();
      t_locked();
      t_collide();
      t_lowbits();
      t_isolate();
      t_comb_read();
      t_rereset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule